// File: doc/BRIEF.md
# Power-Down Sequencer for a Clock Generator

This block orders the entry into and exit from the low-power state of a clock generator. An asynchronous, active-low power-down request is first synchronized. The block then waits for the gated output clocks to finish their current cycle and holds them low. Only one cycle after that hold is in place does it switch off the VCO and the crystal oscillator. While the block is powered down it tristates the serial configuration pins. It does not touch the configuration registers, so their contents survive. On release the oscillator and VCO come back on. A counter stands in for analog settling and runs for a fixed number of reference cycles. Only after that count does the block drop the clock hold and give the serial pins back.

The request has effect only while the mode pin is 0, which selects power-management operation. The CPU and bus stop requests are also synchronized and passed on as halt controls, but only while the sequencer is running normally in power-management mode. During any part of the power-down sequence they are ignored. The sequencer runs on the always-present reference clock so that it can see the release while the CPU clock is stopped. A `cycle_end_i` strobe from the clock dividers marks the ends of the gated-clock cycles.

Top module: `pdseq_top`

## Requirements
- R1: After synchronous reset the outputs are osc_en_o=1, vco_en_o=1, hold_low_o=0, ser_tri_o=0, cpu_halt_o=0 and bus_halt_o=0.
- R2: While mode_i=1, a low pd_n_i changes none of the outputs and no power-down sequence starts.
- R3: With mode_i=0, pd_n_i passes through a 2-stage synchronizer, and the sequencer enters parking on the third rising edge after pd_n_i falls. hold_low_o rises on the first edge after that at which cycle_end_i is sampled high. Until then all outputs keep their running values.
- R4: osc_en_o and vco_en_o fall exactly one cycle after hold_low_o rises, and neither is ever low while hold_low_o is low.
- R5: While powered down (and pd_n_i stays low) the outputs are osc_en_o=0, vco_en_o=0, hold_low_o=1 and ser_tri_o=1.
- R6: After pd_n_i rises, osc_en_o and vco_en_o return to 1 on the third rising edge. hold_low_o and ser_tri_o stay 1 for exactly SETTLE_CYCLES further cycles and then both fall to 0 on the same edge.
- R7: cpu_halt_o and bus_halt_o equal the inverted cpu_stop_n_i and bus_stop_n_i, delayed by two rising edges, only while running with mode_i=0. Otherwise both are 0, including the whole time the power-down sequence is active.
- R8: mode_i rising while powered down acts as a release: on the next rising edge the oscillator and VCO turn back on and the settle count starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, keeps running during power-down |
| rst_i | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Asynchronous power-down request, active low |
| mode_i | input | 1 | 0 selects power-management operation |
| cycle_end_i | input | 1 | Strobe marking the end of the current gated-clock cycle |
| cpu_stop_n_i | input | 1 | Asynchronous CPU clock stop request, active low |
| bus_stop_n_i | input | 1 | Asynchronous bus clock stop request, active low |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| hold_low_o | output | 1 | Hold all gated output clocks low |
| ser_tri_o | output | 1 | Tristate the serial configuration pins |
| cpu_halt_o | output | 1 | Stop the CPU clocks |
| bus_halt_o | output | 1 | Stop the bus clocks |

## Verification
A wrong state in the sequencer shows at once as a forbidden output pattern. Examples are the oscillator off while the clocks are not held, or serial pins still driven while the oscillator is off. Each such pattern appears on the first cycle after the bad transition. A miscounted settle shows as hold_low_o and ser_tri_o falling one or more cycles early or late relative to the release edge. A stuck or lost synchronizer stage moves every entry and exit by a cycle. The bench sweeps the delay before the cycle-end strobe, the modes and all combinations of the stop requests, and compares each cycle against arithmetically derived patterns.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PARK   = 2'd1,
        ST_OFF    = 2'd2,
        ST_SETTLE = 2'd3
    } pd_state_e;

    typedef struct packed {
        logic osc_en;
        logic vco_en;
        logic ser_tri;
    } pd_ctrl_t;

    // Analog-facing controls as a pure function of the sequencer state.
    function automatic pd_ctrl_t ctrl_of(pd_state_e s);
        pd_ctrl_t c;
        c.osc_en  = (s != ST_OFF);
        c.vco_en  = (s != ST_OFF);
        c.ser_tri = (s == ST_OFF) || (s == ST_SETTLE);
        return c;
    endfunction

    function automatic int cnt_width(int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= (g == 0) ? d_i : stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pdseq_settle.sv
module pdseq_settle #(
    parameter int LIMIT = 40000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = pdseq_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

    // R6: the settle counter never passes its terminal value
    a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pd_req_i,
    input  logic      mode_i,
    input  logic      cycle_end_i,
    input  logic      settle_done_i,
    output pd_state_e state_o,
    output logic      hold_low_o,
    output logic      settle_run_o
);
    pd_state_e state_q, state_d;
    logic      hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (pd_req_i && !mode_i)   state_d = ST_PARK;
            ST_PARK:   if (hold_q)                state_d = ST_OFF;
            ST_OFF:    if (!pd_req_i || mode_i)   state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done_i)         state_d = ST_RUN;
            default:                              state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_RUN;
            hold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PARK && cycle_end_i) begin
                hold_q <= 1'b1;
            end else if (state_q == ST_SETTLE && settle_done_i) begin
                hold_q <= 1'b0;
            end
        end
    end

    assign state_o      = state_q;
    assign hold_low_o   = hold_q;
    assign settle_run_o = (state_q == ST_SETTLE);

    // R2: a request in the non-management mode never leaves the run state
    a_r2_mode_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && mode_i) |=> (state_q == ST_RUN));
    // R3: the hold is only taken up from the parking state
    a_r3_hold_from_park: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold_q) |-> $past(state_q == ST_PARK));
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
    import pdseq_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 40000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pd_n_i,
    input  logic mode_i,
    input  logic cycle_end_i,
    input  logic cpu_stop_n_i,
    input  logic bus_stop_n_i,
    output logic osc_en_o,
    output logic vco_en_o,
    output logic hold_low_o,
    output logic ser_tri_o,
    output logic cpu_halt_o,
    output logic bus_halt_o
);
    localparam int NREQ = 3;

    logic [NREQ-1:0] req_raw, req_sync;
    pd_state_e       state;
    pd_ctrl_t        ctrl;
    logic            settle_run, settle_done;

    assign req_raw = {~pd_n_i, ~cpu_stop_n_i, ~bus_stop_n_i};

    pdseq_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (req_raw),
        .q_o   (req_sync)
    );

    pdseq_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .pd_req_i      (req_sync[2]),
        .mode_i        (mode_i),
        .cycle_end_i   (cycle_end_i),
        .settle_done_i (settle_done),
        .state_o       (state),
        .hold_low_o    (hold_low_o),
        .settle_run_o  (settle_run)
    );

    pdseq_settle #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (settle_run),
        .done_o (settle_done)
    );

    assign ctrl      = ctrl_of(state);
    assign osc_en_o  = ctrl.osc_en;
    assign vco_en_o  = ctrl.vco_en;
    assign ser_tri_o = ctrl.ser_tri;

    logic halt_ok;
    assign halt_ok    = (state == ST_RUN) && !mode_i;
    assign cpu_halt_o = halt_ok && req_sync[1];
    assign bus_halt_o = halt_ok && req_sync[0];

    // R4: oscillator is never off unless the clocks are already held
    a_r4_osc_needs_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !osc_en_o |-> hold_low_o);
    // R4: oscillator drops only after the hold was in place a cycle earlier
    a_r4_osc_fall_order: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(osc_en_o) |-> $past(hold_low_o));
    // R5: serial pins are released whenever the oscillator is off
    a_r5_tri_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !vco_en_o |-> ser_tri_o);
    // R6: hold and serial tristate leave together
    a_r6_joint_release: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ser_tri_o) |-> !hold_low_o);
    // R7: stop requests are ignored during the power-down sequence
    a_r7_no_halt_when_held: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_low_o |-> !(cpu_halt_o || bus_halt_o));
endmodule

// File: tb/sim_pdseq_top.sv
`timescale 1ns/1ps
module sim_pdseq_top;
    localparam int S = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_n = 1'b1, mode = 1'b0, cyc_end = 1'b0;
    logic cpu_n = 1'b1, bus_n = 1'b1;
    logic osc, vco, hold, tri_s, chalt, bhalt;
    int checks = 0;
    int errors = 0;

    localparam logic [5:0] P_RUN    = 6'b110000;
    localparam logic [5:0] P_HELD   = 6'b111000;
    localparam logic [5:0] P_OFF    = 6'b001100;
    localparam logic [5:0] P_SETTLE = 6'b111100;

    always #2.5 clk = ~clk;

    pdseq_top #(.SYNC_STAGES(2), .SETTLE_CYCLES(S)) u0 (
        .clk_i(clk), .rst_i(rst), .pd_n_i(pd_n), .mode_i(mode),
        .cycle_end_i(cyc_end), .cpu_stop_n_i(cpu_n), .bus_stop_n_i(bus_n),
        .osc_en_o(osc), .vco_en_o(vco), .hold_low_o(hold),
        .ser_tri_o(tri_s), .cpu_halt_o(chalt), .bus_halt_o(bhalt)
    );

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {osc, vco, hold, tri_s, chalt, bhalt};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pd_seq(input int d);
        pd_n = 1'b0;
        tick(3);
        chk("R3 parked, no change before cycle end", P_RUN);
        for (int i = 0; i < d; i++) begin
            tick(1);
            chk("R3 waiting for cycle end", P_RUN);
        end
        cyc_end = 1'b1;
        tick(1);
        chk("R3 hold on cycle end", P_HELD);
        cyc_end = 1'b0;
        tick(1);
        chk("R4 oscillator off one cycle after hold", P_OFF);
        cpu_n = 1'b0; bus_n = 1'b0;
        tick(3);
        chk("R5 R7 powered down, stops ignored", P_OFF);
        cpu_n = 1'b1; bus_n = 1'b1;
        pd_n = 1'b1;
        tick(2);
        chk("R6 still off two edges after release", P_OFF);
        tick(1);
        chk("R6 oscillator back on third edge", P_SETTLE);
        tick(S - 1);
        chk("R6 hold kept through settle", P_SETTLE);
        tick(1);
        chk("R6 release after settle count", P_RUN);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1 outputs during reset", P_RUN);
        rst = 1'b0;
        tick(1);
        chk("R1 outputs after reset", P_RUN);

        // R2: request with mode 1 has no effect
        mode = 1'b1;
        pd_n = 1'b0;
        cyc_end = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            chk("R2 mode 1 ignores request", P_RUN);
        end
        cyc_end = 1'b0;
        pd_n = 1'b1;
        mode = 1'b0;
        tick(3);

        // R3..R6: sweep delay before the cycle-end strobe
        for (int d = 0; d < 4; d++) begin
            pd_seq(d);
        end

        // R7: stop requests in both modes, all combinations
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            for (int c = 0; c < 4; c++) begin
                cpu_n = c[1]; bus_n = c[0];
                tick(1);
                tick(1);
                chk("R7 halt follows stop request",
                    {4'b1100, (m == 0) ? ~c[1] : 1'b0, (m == 0) ? ~c[0] : 1'b0});
                cpu_n = 1'b1; bus_n = 1'b1;
                tick(2);
            end
        end
        mode = 1'b0;
        tick(1);

        // R8: mode rising while powered down releases
        pd_n = 1'b0;
        tick(3);
        cyc_end = 1'b1;
        tick(1);
        cyc_end = 1'b0;
        tick(1);
        chk("R8 powered down before mode change", P_OFF);
        tick(2);
        mode = 1'b1;
        tick(1);
        chk("R8 mode 1 wakes oscillator", P_SETTLE);
        pd_n = 1'b1;
        mode = 1'b0;
        tick(S - 1);
        chk("R8 settle still running", P_SETTLE);
        tick(1);
        chk("R8 back to run after settle", P_RUN);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule